// File: doc/BRIEF.md
# Burst Bus Target Handshake Engine

This block produces the target side of the handshake on a burst bus that uses ready and stop signalling. While the transaction-active input is high, it answers with a target-ready, a stop, an abort flag and two parity controls. All of them are registered. Wait states, disconnects, aborts and parity error injection are set by static configuration inputs. A verification environment can use it as a programmable target model, and a real target can use it as the control core.

A transaction opens on the first clock edge at which the active input is seen high. That edge is the address edge. A data phase completes on an edge where the initiator-ready input is high and target-ready is already high. Phase counts, gap counts and wait counts are cleared when a transaction opens. The retry budget is the exception: it counts across transactions and clears only on reset. When the active input drops, all handshake outputs fall on the next edge.

Top module: `tgt_resp_gen`

## Requirements
- R1: While reset is high, and on the first edge after it, trdy_o, stop_o, tabort_o, par_flip_o and perr_o are all 0.
- R2: Counting the address edge as edge 0, trdy_o first rises at edge 1+init_waits_i when wait_en_i is 1, and at edge 1 when wait_en_i is 0.
- R3: With wait_en_i=1 and subs_waits_i=S>0, trdy_o drops after every G-th completed data phase since the last wait, where G is xfer_gap_i (0 is treated as 1). It stays low for S cycles and then rises again.
- R4: A data phase completes only on an edge where irdy_i and trdy_o are both 1. While irdy_i is 0, trdy_o holds and no phase-count event occurs.
- R5: With stop_en_i=1, the data phase numbered stop_after_i (first phase = 1) drops trdy_o. stop_o then rises stop_idle_i+1 edges later and holds, and trdy_o stays 0 while stop_o is 1.
- R6: With abort_en_i=1, the phase numbered abort_after_i raises stop_o and tabort_o and drops trdy_o at that same edge. Abort takes priority over a stop due at the same phase, and a stop takes priority over a wait due at the same phase.
- R7: With retry_lim_en_i=1, once retry_lim_i disconnect stops have been issued since reset, no further disconnect stop is issued.
- R8: par_flip_o is 1 exactly in cycles where trdy_o is 1 and bad_par_en_i is 1 (inverted parity over the low 32 data bits).
- R9: perr_o is 1 for the cycle after a completed data phase in which par_err_i or force_perr_i was 1, and is 0 otherwise.
- R10: On the edge after frame_i is seen low, trdy_o, stop_o and tabort_o are 0. A new transaction restarts all per-transaction counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Transaction active |
| irdy_i | input | 1 | Initiator ready |
| par_err_i | input | 1 | Received parity mismatch, computed outside the block |
| wait_en_i | input | 1 | Enable wait-state insertion |
| init_waits_i | input | CW | Wait cycles before the first trdy |
| subs_waits_i | input | CW | Wait cycles before each later trdy group |
| xfer_gap_i | input | CW | Completed phases between wait groups |
| stop_en_i | input | 1 | Enable disconnect stop |
| stop_after_i | input | CW | Phase number that triggers the disconnect |
| stop_idle_i | input | CW | Extra idle cycles before stop rises |
| retry_lim_en_i | input | 1 | Enable the retry budget |
| retry_lim_i | input | CW | Number of stops allowed since reset |
| abort_en_i | input | 1 | Enable target abort |
| abort_after_i | input | CW | Phase number that triggers the abort |
| bad_par_en_i | input | 1 | Request inverted parity on driven data |
| force_perr_i | input | 1 | Flag a parity error regardless of data |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Stop |
| tabort_o | output | 1 | Target abort flag |
| par_flip_o | output | 1 | Invert parity of the low 32 bits |
| perr_o | output | 1 | Parity error flag |

## Verification
Two pairs of triggers can land on the same data phase: abort with stop, and stop with a subsequent wait. In each pair, only the winning trigger may affect the outputs. The bench provokes each collision by giving both triggers the same phase number. It then compares the whole trdy_o, stop_o and tabort_o patterns over sixteen cycles against patterns worked out by hand. These patterns show an immediate abort rather than a delayed stop, and an idle-then-stop rather than a wait followed by renewed readiness.

// File: rtl/tgt_pkg.sv
package tgt_pkg;
  typedef enum logic [2:0] {
    TS_IDLE,
    TS_WAIT,
    TS_XFER,
    TS_SDLY,
    TS_END
  } tgt_state_e;
endpackage

// File: rtl/tgt_down_ctr.sv
module tgt_down_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= val_i;
    end else if (dec_i && cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/tgt_phase_ctr.sv
module tgt_phase_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         done_i,
  input  logic         gap_clr_i,
  output logic [W-1:0] phase_next_o,
  output logic [W-1:0] gap_next_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] phase_q;
  logic [W-1:0] gap_q;

  assign phase_next_o = (phase_q == MAXV) ? MAXV : phase_q + W'(1);
  assign gap_next_o   = (gap_q == MAXV) ? MAXV : gap_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      phase_q <= '0;
      gap_q   <= '0;
    end else if (done_i) begin
      phase_q <= phase_next_o;
      gap_q   <= gap_clr_i ? '0 : gap_next_o;
    end
  end
endmodule

// File: rtl/tgt_retry_budget.sv
module tgt_retry_budget #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hit_i,
  input  logic         lim_en_i,
  input  logic [W-1:0] lim_i,
  output logic         live_o
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
    end else if (hit_i && used_q != MAXV) begin
      used_q <= used_q + W'(1);
    end
  end

  assign live_o = !(lim_en_i && (used_q >= lim_i));
endmodule

// File: rtl/tgt_resp_gen.sv
module tgt_resp_gen
  import tgt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_i,
  input  logic          irdy_i,
  input  logic          par_err_i,
  input  logic          wait_en_i,
  input  logic [CW-1:0] init_waits_i,
  input  logic [CW-1:0] subs_waits_i,
  input  logic [CW-1:0] xfer_gap_i,
  input  logic          stop_en_i,
  input  logic [CW-1:0] stop_after_i,
  input  logic [CW-1:0] stop_idle_i,
  input  logic          retry_lim_en_i,
  input  logic [CW-1:0] retry_lim_i,
  input  logic          abort_en_i,
  input  logic [CW-1:0] abort_after_i,
  input  logic          bad_par_en_i,
  input  logic          force_perr_i,
  output logic          trdy_o,
  output logic          stop_o,
  output logic          tabort_o,
  output logic          par_flip_o,
  output logic          perr_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  tgt_state_e st, st_n;
  logic trdy_n, stop_n, tabort_n;
  logic cnt_load, cnt_dec, cnt_zero;
  logic [CW-1:0] cnt_val;
  logic ph_clr, gap_clr, done, retry_hit, stop_live;
  logic [CW-1:0] phase_next, gap_next, gap_eff;
  logic abort_hit, stop_hit, wait_hit;

  tgt_down_ctr #(.W(CW)) u_wcnt (
    .clk(clk), .rst(rst), .load_i(cnt_load), .val_i(cnt_val),
    .dec_i(cnt_dec), .zero_o(cnt_zero)
  );

  tgt_phase_ctr #(.W(CW)) u_phase (
    .clk(clk), .rst(rst), .clr_i(ph_clr), .done_i(done),
    .gap_clr_i(gap_clr), .phase_next_o(phase_next), .gap_next_o(gap_next)
  );

  tgt_retry_budget #(.W(CW)) u_retry (
    .clk(clk), .rst(rst), .hit_i(retry_hit), .lim_en_i(retry_lim_en_i),
    .lim_i(retry_lim_i), .live_o(stop_live)
  );

  assign done      = (st == TS_XFER) && irdy_i && frame_i;
  assign gap_eff   = (xfer_gap_i == '0) ? ONE : xfer_gap_i;
  assign abort_hit = abort_en_i && (phase_next == abort_after_i);
  assign stop_hit  = stop_en_i && stop_live && (phase_next == stop_after_i);
  assign wait_hit  = wait_en_i && (subs_waits_i != '0) && (gap_next >= gap_eff);

  always_comb begin
    st_n      = st;
    trdy_n    = trdy_o;
    stop_n    = stop_o;
    tabort_n  = tabort_o;
    cnt_load  = 1'b0;
    cnt_val   = '0;
    cnt_dec   = 1'b0;
    ph_clr    = 1'b0;
    gap_clr   = 1'b0;
    retry_hit = 1'b0;
    if (!frame_i) begin
      st_n     = TS_IDLE;
      trdy_n   = 1'b0;
      stop_n   = 1'b0;
      tabort_n = 1'b0;
    end else begin
      case (st)
        TS_IDLE: begin
          st_n     = TS_WAIT;
          cnt_load = 1'b1;
          cnt_val  = wait_en_i ? init_waits_i : '0;
          ph_clr   = 1'b1;
        end
        TS_WAIT: begin
          if (cnt_zero) begin
            trdy_n = 1'b1;
            st_n   = TS_XFER;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        TS_XFER: begin
          if (irdy_i) begin
            if (abort_hit) begin
              trdy_n   = 1'b0;
              stop_n   = 1'b1;
              tabort_n = 1'b1;
              st_n     = TS_END;
            end else if (stop_hit) begin
              trdy_n   = 1'b0;
              cnt_load = 1'b1;
              cnt_val  = stop_idle_i;
              st_n     = TS_SDLY;
            end else if (wait_hit) begin
              trdy_n   = 1'b0;
              cnt_load = 1'b1;
              cnt_val  = subs_waits_i - ONE;
              gap_clr  = 1'b1;
              st_n     = TS_WAIT;
            end
          end
        end
        TS_SDLY: begin
          if (cnt_zero) begin
            stop_n    = 1'b1;
            retry_hit = 1'b1;
            st_n      = TS_END;
          end else begin
            cnt_dec = 1'b1;
          end
        end
        TS_END: begin
          st_n = TS_END;
        end
        default: st_n = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= TS_IDLE;
      trdy_o     <= 1'b0;
      stop_o     <= 1'b0;
      tabort_o   <= 1'b0;
      par_flip_o <= 1'b0;
      perr_o     <= 1'b0;
    end else begin
      st         <= st_n;
      trdy_o     <= trdy_n;
      stop_o     <= stop_n;
      tabort_o   <= tabort_n;
      par_flip_o <= bad_par_en_i && trdy_n;
      perr_o     <= done && (par_err_i || force_perr_i);
    end
  end
endmodule

// File: rtl/tgt_resp_chk.sv
module tgt_resp_chk (
  input logic clk,
  input logic rst,
  input logic frame_i,
  input logic irdy_i,
  input logic trdy_o,
  input logic stop_o,
  input logic tabort_o,
  input logic par_flip_o,
  input logic perr_o
);
  // R5
  stop_hides_ready_chk: assert property (@(posedge clk) disable iff (rst)
    stop_o |-> !trdy_o);

  // R6
  abort_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    tabort_o |-> stop_o);

  // R8
  flip_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    par_flip_o |-> trdy_o);

  // R10
  frame_drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_i |=> (!trdy_o && !stop_o && !tabort_o));

  // R9
  perr_after_phase_chk: assert property (@(posedge clk) disable iff (rst)
    perr_o |-> $past(trdy_o && irdy_i && frame_i));
endmodule

bind tgt_resp_gen tgt_resp_chk u_chk (
  .clk(clk), .rst(rst), .frame_i(frame_i), .irdy_i(irdy_i),
  .trdy_o(trdy_o), .stop_o(stop_o), .tabort_o(tabort_o),
  .par_flip_o(par_flip_o), .perr_o(perr_o)
);

// File: tb/sim_tgt_resp_gen.sv
`timescale 1ns/1ps
module sim_tgt_resp_gen;
  localparam int CW = 8;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_i = 0, irdy_i = 0, par_err_i = 0, wait_en_i = 0;
  logic [CW-1:0] init_waits_i = '0, subs_waits_i = '0, xfer_gap_i = '0;
  logic stop_en_i = 0;
  logic [CW-1:0] stop_after_i = '0, stop_idle_i = '0;
  logic retry_lim_en_i = 0;
  logic [CW-1:0] retry_lim_i = '0;
  logic abort_en_i = 0;
  logic [CW-1:0] abort_after_i = '0;
  logic bad_par_en_i = 0, force_perr_i = 0;
  logic trdy_o, stop_o, tabort_o, par_flip_o, perr_o;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  tgt_resp_gen #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .frame_i(frame_i), .irdy_i(irdy_i),
    .par_err_i(par_err_i), .wait_en_i(wait_en_i), .init_waits_i(init_waits_i),
    .subs_waits_i(subs_waits_i), .xfer_gap_i(xfer_gap_i), .stop_en_i(stop_en_i),
    .stop_after_i(stop_after_i), .stop_idle_i(stop_idle_i),
    .retry_lim_en_i(retry_lim_en_i), .retry_lim_i(retry_lim_i),
    .abort_en_i(abort_en_i), .abort_after_i(abort_after_i),
    .bad_par_en_i(bad_par_en_i), .force_perr_i(force_perr_i),
    .trdy_o(trdy_o), .stop_o(stop_o), .tabort_o(tabort_o),
    .par_flip_o(par_flip_o), .perr_o(perr_o)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  iw;
    logic [3:0]  sw;
    logic [3:0]  gap;
    logic        se;
    logic [3:0]  sa;
    logic [3:0]  si;
    logic        ae;
    logic [3:0]  aa;
    logic [15:0] et;
    logic [15:0] es;
    logic [15:0] ea;
  } vec_t;

  // bit k of et/es/ea = expected output after edge k (edge 0 = address edge), irdy held 1
  localparam vec_t VECS [NV] = '{
    // R2: one initial wait
    '{1'b1, 4'd1, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'hFFFC, 16'h0000, 16'h0000},
    // R2: waits disabled, init ignored
    '{1'b0, 4'd3, 4'd0, 4'd0, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'hFFFE, 16'h0000, 16'h0000},
    // R3: two waits after every phase
    '{1'b1, 4'd0, 4'd2, 4'd1, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'h2492, 16'h0000, 16'h0000},
    // R3: one wait after every second phase
    '{1'b1, 4'd0, 4'd1, 4'd2, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 16'h6DB6, 16'h0000, 16'h0000},
    // R5: stop after phase 2 plus one idle
    '{1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 4'd2, 4'd1, 1'b0, 4'd0, 16'h0006, 16'hFFE0, 16'h0000},
    // R6: abort and stop both at phase 3, abort wins
    '{1'b0, 4'd0, 4'd0, 4'd0, 1'b1, 4'd3, 4'd2, 1'b1, 4'd3, 16'h000E, 16'hFFF0, 16'hFFF0},
    // R6: stop and wait both at phase 1, stop wins
    '{1'b1, 4'd0, 4'd1, 4'd1, 1'b1, 4'd1, 4'd0, 1'b0, 4'd0, 16'h0002, 16'hFFF8, 16'h0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_clear();
    wait_en_i = 0; init_waits_i = '0; subs_waits_i = '0; xfer_gap_i = '0;
    stop_en_i = 0; stop_after_i = '0; stop_idle_i = '0;
    retry_lim_en_i = 0; retry_lim_i = '0;
    abort_en_i = 0; abort_after_i = '0;
    bad_par_en_i = 0; force_perr_i = 0; par_err_i = 0;
  endtask

  task automatic end_txn();
    frame_i = 0; irdy_i = 0;
    cyc();
    cyc();
  endtask

  task automatic do_reset();
    rst = 1;
    cyc();
    cyc();
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] at, as, aa;
    cfg_clear();
    @(negedge clk);
    cyc();
    // R1: outputs low during reset
    chk("R1 reset", {trdy_o, stop_o, tabort_o, par_flip_o, perr_o}, 0);
    rst = 0;
    cyc();
    chk("R1 after reset", {trdy_o, stop_o, tabort_o, par_flip_o, perr_o}, 0);

    for (int v = 0; v < NV; v++) begin
      cfg_clear();
      wait_en_i = VECS[v].we; init_waits_i = CW'(VECS[v].iw);
      subs_waits_i = CW'(VECS[v].sw); xfer_gap_i = CW'(VECS[v].gap);
      stop_en_i = VECS[v].se; stop_after_i = CW'(VECS[v].sa);
      stop_idle_i = CW'(VECS[v].si); abort_en_i = VECS[v].ae;
      abort_after_i = CW'(VECS[v].aa);
      frame_i = 1; irdy_i = 1;
      for (int k = 0; k < 16; k++) begin
        cyc();
        at[k] = trdy_o; as[k] = stop_o; aa[k] = tabort_o;
      end
      chk($sformatf("R2 R3 R5 R6 vec%0d trdy", v), int'(at), int'(VECS[v].et));
      chk($sformatf("R5 R6 vec%0d stop", v), int'(as), int'(VECS[v].es));
      chk($sformatf("R6 vec%0d abort", v), int'(aa), int'(VECS[v].ea));
      frame_i = 0; irdy_i = 0;
      cyc();
      // R10: frame drop clears handshake
      chk($sformatf("R10 vec%0d clear", v), {trdy_o, stop_o, tabort_o}, 0);
      cyc();
    end

    // R4: stall with irdy low keeps trdy and delays the stop
    do_reset();
    cfg_clear();
    stop_en_i = 1; stop_after_i = CW'(1);
    frame_i = 1; irdy_i = 0;
    for (int k = 0; k < 6; k++) cyc();
    chk("R4 stall trdy held", trdy_o, 1);
    chk("R4 stall no stop", stop_o, 0);
    irdy_i = 1;
    cyc();
    chk("R4 phase completes trdy", trdy_o, 0);
    cyc();
    chk("R4 stop follows", stop_o, 1);
    end_txn();

    // R7: budget of two stops
    do_reset();
    cfg_clear();
    stop_en_i = 1; stop_after_i = CW'(1);
    retry_lim_en_i = 1; retry_lim_i = CW'(2);
    for (int t = 0; t < 3; t++) begin
      frame_i = 1; irdy_i = 1;
      for (int k = 0; k < 6; k++) cyc();
      chk($sformatf("R7 txn%0d stop", t), stop_o, (t < 2) ? 1 : 0);
      chk($sformatf("R7 txn%0d trdy", t), trdy_o, (t < 2) ? 0 : 1);
      end_txn();
    end

    // R8: parity flip follows trdy
    cfg_clear();
    bad_par_en_i = 1; wait_en_i = 1; init_waits_i = CW'(1);
    frame_i = 1; irdy_i = 1;
    cyc();
    cyc();
    chk("R8 flip low in wait", par_flip_o, 0);
    cyc();
    chk("R8 flip with trdy", par_flip_o, 1);
    bad_par_en_i = 0;
    cyc();
    chk("R8 flip off", par_flip_o, 0);
    end_txn();

    // R9: forced parity error
    cfg_clear();
    force_perr_i = 1;
    frame_i = 1; irdy_i = 1;
    cyc();
    cyc();
    chk("R9 no phase yet", perr_o, 0);
    cyc();
    chk("R9 forced flag", perr_o, 1);
    end_txn();

    // R9: received error needs a completed phase
    cfg_clear();
    par_err_i = 1;
    frame_i = 1; irdy_i = 0;
    for (int k = 0; k < 4; k++) cyc();
    chk("R9 no phase no flag", perr_o, 0);
    irdy_i = 1;
    cyc();
    chk("R9 mismatch flagged", perr_o, 1);
    par_err_i = 0;
    cyc();
    chk("R9 clean phase", perr_o, 0);
    end_txn();

    // R10: new transaction restarts initial waits
    cfg_clear();
    wait_en_i = 1; init_waits_i = CW'(2);
    frame_i = 1; irdy_i = 1;
    for (int k = 0; k < 3; k++) cyc();
    chk("R10 restart wait", trdy_o, 0);
    cyc();
    chk("R10 restart ready", trdy_o, 1);
    end_txn();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule